// File: doc/BRIEF.md
# Watchdog and Reset Source Manager

This block produces the chip-wide reset and keeps a record of why the last reset happened. Four things can reset the chip. A power-good input rising from low gives a stretched power-up reset. An external active-low reset pin counts only after it has stayed low long enough. A USB bus-reset indication from the serial interface engine resets the chip while it is present. A watchdog counter resets the chip if software stops feeding it. The watchdog has no disable. The only way to restart it is to write one exact key byte to its feed address.

The block also controls suspend. Software writes two key bytes back to back at two key addresses, and the block then asks the clock source to stop. A wake input, driven by host resume or a remote key press, ends suspend with a warm reset. A two-bit status register lets software after reset tell a cold start (power-up flag set) from a warm one. Among warm starts it separates a resume (suspend flag set) from a watchdog expiry (suspend flag clear). Software reads the flags on a status port and writes the register through a simple write strobe.

Top module: `rst_supervisor`

## Requirements
- R1: While power-good is low, chipReset is 1, oscStopReq is 0 and statusByte reads 02h. After power-good rises, chipReset stays 1 for POR_CYCLES clock edges and then drops.
- R2: If the watchdog is not fed for WDT_LIMIT consecutive running cycles, chipReset rises on the WDT_LIMIT-th edge after the last feed or after reset release.
- R3: Only a write of 55h to the feed address restarts the watchdog. A write of any other value there leaves the count running.
- R4: The watchdog does not count while chipReset is 1 or while the block is suspended.
- R5: The external pin causes a reset only after it has been sampled low on EXT_MIN consecutive edges. A shorter low pulse has no effect on chipReset.
- R6: A USB bus-reset indication asserts chipReset on the edge that samples it.
- R7: statusByte has the power-up flag at bit 1, the suspend flag at bit 0, and zeros above. A cold cause (power-up, external pin, USB bus reset) sets the power-up flag and clears the suspend flag. A watchdog reset clears the suspend flag and leaves the power-up flag unchanged. A wake reset sets the suspend flag and leaves the power-up flag unchanged.
- R8: A write to the mode address clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Software can never set a flag.
- R9: A write of 55h to suspend key address A, immediately followed by a write of AAh to key address B as the next write, raises oscStopReq.
- R10: Any other write between the two key writes cancels the sequence, and oscStopReq stays 0.
- R11: The wake input while suspended drops oscStopReq and starts a warm reset on the edge that samples it. The wake input outside suspend is ignored.
- R12: Writes made while chipReset is 1 are ignored.
- R13: After the last reset cause goes away, chipReset stays 1 for RST_HOLD more edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerGood | input | 1 | Supply good, low means power is absent (asynchronous, active-low block reset) |
| extResetN | input | 1 | External reset pin, active low |
| usbBusReset | input | 1 | USB bus-reset indication from the serial engine |
| wakeEvent | input | 1 | Resume or remote-wake event |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| chipReset | output | 1 | Chip reset, active high |
| oscStopReq | output | 1 | Request to stop the oscillator (suspend) |
| statusByte | output | DATA_W | Mode/status flags |

## Verification
The bound checker watches rules that must hold on every cycle. The oscillator-stop request never overlaps a chip reset and can only fall together with one. Neither flag can rise outside a reset. Writes during reset cannot clear the power-up flag. A USB bus reset always asserts chipReset on the next cycle. The exact watchdog expiry cycle, the rejection of a wrong feed key, the 9-versus-12-cycle pin qualification, the aborted suspend sequence, the watchdog halting through a long suspend, and the flag values left by each kind of reset all depend on ordered stimulus. Only the bench scenarios can show those.

// File: rtl/rst_supervisor_pkg.sv
package rst_supervisor_pkg;

  localparam logic [7:0] KEY_FEED      = 8'h55;
  localparam logic [7:0] KEY_SUSPEND_1 = 8'h55;
  localparam logic [7:0] KEY_SUSPEND_2 = 8'hAA;

  typedef struct packed {
    logic wdtFeed;
    logic wdtHalt;
    logic wakeReset;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_COLD,
    CAUSE_WDT,
    CAUSE_WAKE
  } resetCause_t;

endpackage

// File: rtl/rst_supervisor_dp.sv
module rst_supervisor_dp
  import rst_supervisor_pkg::*;
#(
  parameter int WDT_LIMIT  = 900000,
  parameter int POR_CYCLES = 30000,
  parameter int EXT_MIN    = 10,
  parameter int RST_HOLD   = 16
) (
  input  logic         clk,
  input  logic         powerGood,
  input  logic         extResetN,
  input  logic         usbBusReset,
  input  ctrlStrobes_t strobes,
  output logic         chipReset,
  output logic         coldReq,
  output logic         wdtExpire
);

  localparam int WDT_W  = $clog2(WDT_LIMIT);
  localparam int POR_W  = $clog2(POR_CYCLES + 1);
  localparam int EXT_W  = $clog2(EXT_MIN + 1);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [WDT_W-1:0]  wdtCnt;
  logic [POR_W-1:0]  porCnt;
  logic [EXT_W-1:0]  extLowCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              extQualified;
  logic              loadHold;

  always_comb begin
    extQualified = (extLowCnt >= EXT_W'(EXT_MIN));
    coldReq      = extQualified || usbBusReset;
    chipReset    = (porCnt != '0) || (holdCnt != '0);
    wdtExpire    = !chipReset && !strobes.wdtHalt &&
                   (wdtCnt == WDT_W'(WDT_LIMIT - 1));
    loadHold     = coldReq || wdtExpire || strobes.wakeReset;
  end

  // power-up stretch
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)            porCnt <= POR_W'(POR_CYCLES);
    else if (porCnt != '0)     porCnt <= porCnt - 1'b1;
  end

  // external pin qualifier: consecutive low samples, saturating
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)            extLowCnt <= '0;
    else if (extResetN)        extLowCnt <= '0;
    else if (!extQualified)    extLowCnt <= extLowCnt + 1'b1;
  end

  // reset hold stretch after any event
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)            holdCnt <= '0;
    else if (loadHold)         holdCnt <= HOLD_W'(RST_HOLD);
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  // watchdog counter
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                       wdtCnt <= '0;
    else if (chipReset || strobes.wdtFeed) wdtCnt <= '0;
    else if (strobes.wdtHalt)             wdtCnt <= wdtCnt;
    else if (wdtExpire)                   wdtCnt <= '0;
    else                                  wdtCnt <= wdtCnt + 1'b1;
  end

endmodule

// File: rtl/rst_supervisor_ctrl.sv
module rst_supervisor_ctrl
  import rst_supervisor_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_FEED = 4'h3,
  parameter logic [ADDR_W-1:0] ADDR_MODE = 4'h4,
  parameter logic [ADDR_W-1:0] ADDR_SUSA = 4'hA,
  parameter logic [ADDR_W-1:0] ADDR_SUSB = 4'hB
) (
  input  logic              clk,
  input  logic              powerGood,
  input  logic              wakeEvent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              chipReset,
  input  logic              coldReq,
  input  logic              wdtExpire,
  output ctrlStrobes_t      strobes,
  output logic              oscStopReq,
  output logic [DATA_W-1:0] statusByte
);

  logic        pofFlag;
  logic        susFlag;
  logic        suspended;
  logic        armed;
  logic        wrAccept;
  logic        keyAHit;
  logic        keyBHit;
  logic        wakeHit;
  resetCause_t cause;

  always_comb begin
    wrAccept = wrEn && !chipReset && !suspended;
    keyAHit  = (wrAddr == ADDR_SUSA) && (wrData == DATA_W'(KEY_SUSPEND_1));
    keyBHit  = (wrAddr == ADDR_SUSB) && (wrData == DATA_W'(KEY_SUSPEND_2));
    wakeHit  = wakeEvent && suspended;

    if (coldReq)        cause = CAUSE_COLD;
    else if (wdtExpire) cause = CAUSE_WDT;
    else if (wakeHit)   cause = CAUSE_WAKE;
    else                cause = CAUSE_NONE;

    strobes.wdtFeed   = wrAccept && (wrAddr == ADDR_FEED) &&
                        (wrData == DATA_W'(KEY_FEED));
    strobes.wdtHalt   = suspended;
    strobes.wakeReset = wakeHit;

    oscStopReq = suspended;
    statusByte = {{(DATA_W-2){1'b0}}, pofFlag, susFlag};
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      pofFlag   <= 1'b1;
      susFlag   <= 1'b0;
      suspended <= 1'b0;
      armed     <= 1'b0;
    end else begin
      unique case (cause)
        CAUSE_COLD: begin
          pofFlag   <= 1'b1;
          susFlag   <= 1'b0;
          suspended <= 1'b0;
          armed     <= 1'b0;
        end
        CAUSE_WDT: begin
          susFlag   <= 1'b0;
          suspended <= 1'b0;
          armed     <= 1'b0;
        end
        CAUSE_WAKE: begin
          susFlag   <= 1'b1;
          suspended <= 1'b0;
          armed     <= 1'b0;
        end
        default: begin
          if (wrAccept) begin
            if (wrAddr == ADDR_MODE) begin
              pofFlag <= pofFlag & wrData[1];
              susFlag <= susFlag & wrData[0];
            end
            if (armed && keyBHit) begin
              suspended <= 1'b1;
              armed     <= 1'b0;
            end else begin
              armed <= keyAHit;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_supervisor_pkg::*;
#(
  parameter int WDT_LIMIT  = 900000,
  parameter int POR_CYCLES = 30000,
  parameter int EXT_MIN    = 10,
  parameter int RST_HOLD   = 16,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_FEED = 4'h3,
  parameter logic [ADDR_W-1:0] ADDR_MODE = 4'h4,
  parameter logic [ADDR_W-1:0] ADDR_SUSA = 4'hA,
  parameter logic [ADDR_W-1:0] ADDR_SUSB = 4'hB
) (
  input  logic              clk,
  input  logic              powerGood,
  input  logic              extResetN,
  input  logic              usbBusReset,
  input  logic              wakeEvent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              chipReset,
  output logic              oscStopReq,
  output logic [DATA_W-1:0] statusByte
);

  ctrlStrobes_t strobes;
  logic         coldReq;
  logic         wdtExpire;

  rst_supervisor_dp #(
    .WDT_LIMIT (WDT_LIMIT),
    .POR_CYCLES(POR_CYCLES),
    .EXT_MIN   (EXT_MIN),
    .RST_HOLD  (RST_HOLD)
  ) u_dp (
    .clk        (clk),
    .powerGood  (powerGood),
    .extResetN  (extResetN),
    .usbBusReset(usbBusReset),
    .strobes    (strobes),
    .chipReset  (chipReset),
    .coldReq    (coldReq),
    .wdtExpire  (wdtExpire)
  );

  rst_supervisor_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_FEED(ADDR_FEED),
    .ADDR_MODE(ADDR_MODE),
    .ADDR_SUSA(ADDR_SUSA),
    .ADDR_SUSB(ADDR_SUSB)
  ) u_ctrl (
    .clk       (clk),
    .powerGood (powerGood),
    .wakeEvent (wakeEvent),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .chipReset (chipReset),
    .coldReq   (coldReq),
    .wdtExpire (wdtExpire),
    .strobes   (strobes),
    .oscStopReq(oscStopReq),
    .statusByte(statusByte)
  );

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              powerGood,
  input logic              usbBusReset,
  input logic              chipReset,
  input logic              oscStopReq,
  input logic [DATA_W-1:0] statusByte
);

  // R9
  susp_no_reset_chk: assert property (@(posedge clk) disable iff (!powerGood)
    oscStopReq |-> !chipReset);

  // R11
  wake_fall_reset_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(oscStopReq) |-> chipReset);

  // R7
  susflag_rise_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(statusByte[0]) |-> chipReset);

  // R7
  pofflag_rise_chk: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(statusByte[1]) |-> chipReset);

  // R12
  write_in_reset_chk: assert property (@(posedge clk) disable iff (!powerGood)
    ($past(chipReset) && chipReset) |-> !$fell(statusByte[1]));

  // R6
  usb_reset_chk: assert property (@(posedge clk) disable iff (!powerGood)
    usbBusReset |=> chipReset);

endmodule

bind rst_supervisor rst_supervisor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .powerGood  (powerGood),
  .usbBusReset(usbBusReset),
  .chipReset  (chipReset),
  .oscStopReq (oscStopReq),
  .statusByte (statusByte)
);

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;

  localparam int WDT_LIMIT  = 200;
  localparam int POR_CYCLES = 20;
  localparam int EXT_MIN    = 10;
  localparam int RST_HOLD   = 8;
  localparam logic [3:0] A_FEED = 4'h3;
  localparam logic [3:0] A_MODE = 4'h4;
  localparam logic [3:0] A_SUSA = 4'hA;
  localparam logic [3:0] A_SUSB = 4'hB;

  logic       clk = 1'b0;
  logic       powerGood = 1'b0;
  logic       extResetN = 1'b1;
  logic       usbBusReset = 1'b0;
  logic       wakeEvent = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       chipReset;
  logic       oscStopReq;
  logic [7:0] statusByte;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct packed {
    logic       rst;
    logic       osc;
    logic [7:0] st;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  always #5 clk = ~clk;

  rst_supervisor #(
    .WDT_LIMIT(WDT_LIMIT), .POR_CYCLES(POR_CYCLES),
    .EXT_MIN(EXT_MIN), .RST_HOLD(RST_HOLD)
  ) u_rst_supervisor (
    .clk(clk), .powerGood(powerGood), .extResetN(extResetN),
    .usbBusReset(usbBusReset), .wakeEvent(wakeEvent),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chipReset(chipReset), .oscStopReq(oscStopReq), .statusByte(statusByte)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (chipReset !== e.rst || oscStopReq !== e.osc || statusByte !== e.st) begin
        errors++;
        $display("FAIL %s: actual rst=%0b osc=%0b st=%02h expected rst=%0b osc=%0b st=%02h",
                 t, chipReset, oscStopReq, statusByte, e.rst, e.osc, e.st);
      end
    end
  end

  task automatic expectState(input string tag, input logic rst,
                             input logic osc, input logic [7:0] st);
    expItem_t e;
    e.rst = rst; e.osc = osc; e.st = st;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitLevel(input logic lvl, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #1;
      if (chipReset == lvl) break;
    end
  endtask

  task automatic pulseWake();
    @(posedge clk); #1 wakeEvent = 1'b1;
    @(posedge clk); #1 wakeEvent = 1'b0;
  endtask

  task automatic extLow(input int n);
    @(posedge clk); #1 extResetN = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    expectState("R1 reset state", 1, 0, 8'h02);
    #1 powerGood = 1'b1;
    repeat (15) @(posedge clk);
    expectState("R1 stretch still active", 1, 0, 8'h02);
    waitLevel(0, 20);
    expectState("R1 released", 0, 0, 8'h02);

    writeReg(A_MODE, 8'hFF);
    expectState("R8 ones keep flags", 0, 0, 8'h02);
    writeReg(A_MODE, 8'h00);
    expectState("R8 zeros clear flags", 0, 0, 8'h00);

    for (int k = 0; k < 4; k++) begin
      repeat (150) @(posedge clk);
      writeReg(A_FEED, 8'h55);
    end
    expectState("R3 regular feeding", 0, 0, 8'h00);

    writeReg(A_FEED, 8'h55);
    repeat (150) @(posedge clk);
    writeReg(A_FEED, 8'h54);
    repeat (38) @(posedge clk);
    expectState("R3 wrong key ignored, no expiry yet", 0, 0, 8'h00);
    repeat (15) @(posedge clk);
    expectState("R2 watchdog expiry", 1, 0, 8'h00);
    waitLevel(0, 20);
    expectState("R13 released after watchdog", 0, 0, 8'h00);

    writeReg(A_SUSA, 8'h55);
    writeReg(A_SUSB, 8'hAA);
    expectState("R9 suspend entered", 0, 1, 8'h00);
    repeat (400) @(posedge clk);
    expectState("R4 watchdog halted in suspend", 0, 1, 8'h00);

    pulseWake();
    expectState("R11 wake reset, R7 suspend flag", 1, 0, 8'h01);
    waitLevel(0, 20);
    expectState("R7 after resume", 0, 0, 8'h01);

    writeReg(A_SUSA, 8'h55);
    writeReg(A_MODE, 8'hFF);
    writeReg(A_SUSB, 8'hAA);
    expectState("R10 aborted sequence", 0, 0, 8'h01);

    pulseWake();
    repeat (2) @(posedge clk);
    expectState("R11 wake outside suspend ignored", 0, 0, 8'h01);

    waitLevel(1, 250);
    expectState("R7 watchdog clears suspend flag", 1, 0, 8'h00);
    waitLevel(0, 20);

    extLow(9);
    #1 extResetN = 1'b1;
    repeat (3) @(posedge clk);
    expectState("R5 short pin pulse ignored", 0, 0, 8'h00);

    extLow(12);
    expectState("R5 qualified pin reset, R7 cold", 1, 0, 8'h02);
    #1 extResetN = 1'b1;
    waitLevel(0, 20);
    expectState("R5 released", 0, 0, 8'h02);

    writeReg(A_MODE, 8'h00);
    expectState("R8 clear again", 0, 0, 8'h00);
    @(posedge clk); #1 usbBusReset = 1'b1;
    @(posedge clk);
    expectState("R6 usb bus reset", 1, 0, 8'h02);
    writeReg(A_MODE, 8'h00);
    expectState("R12 write during reset ignored", 1, 0, 8'h02);
    usbBusReset = 1'b0;
    repeat (7) @(posedge clk);
    expectState("R13 hold still active", 1, 0, 8'h02);
    @(posedge clk);
    expectState("R13 hold ended", 0, 0, 8'h02);

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule